// File: doc/BRIEF.md
# Tap-Gated FIR Filter with Channel-Driven Configuration

This block is a direct-form FIR filter whose taps can each be switched off at run time. A per-tap enable vector decides which products reach the sum. A tap that is switched off contributes nothing to the output. Its multiplier operand register is not reloaded, so its logic stays quiet and saves switching energy at the cost of filter accuracy.

A small two-state channel monitor picks the enable vector. It watches a received-power estimate on every clock. The monitor goes to the "bad" state when the power drops under a low threshold, and it goes back to "good" only when the power rises above a separate high threshold. The gap between the two thresholds gives hysteresis. Two stored enable vectors sit on the ports, one for each state. The vector for the current state is captured on each accepted input sample, so a change of configuration always lands on a sample boundary. The active vector and the channel state are visible on status outputs.

The datapath has two stages. An accepted sample loads the delay line and the enabled operand registers. The sum of products is then rounded, saturated and registered one clock later.

Top module: `tapfir_top`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0, out_sample is 0, chan_bad is 0 (good) and cfg_active is all zeros.
- R2: For each accepted sample x[n], the output equals the rounded, saturated value of the sum over enabled taps k of coef[k]*x[n-k]. Here x[n-k] is the k-th earlier accepted sample, and it is 0 if fewer than k+1 samples have been accepted since reset. coef[k] is field k (CW bits, signed) of coef_flat, and tap 0 is the newest sample.
- R3: A sample is accepted on a rising clock edge where in_valid is 1. out_valid is 1 for exactly the cycle after the following edge. Cycles with in_valid at 0 produce no output, and out_sample holds its last value between outputs.
- R4: Bit k of the active vector enables tap k. A tap whose bit is 0 adds zero to the sum, and its operand register keeps its previous value.
- R5: The delay line shifts on every accepted sample whatever the enable bits are. A tap that is enabled again therefore uses the correct history.
- R6: Rounding adds 2^(RS-1) to the full-precision sum and then shifts it arithmetically right by RS bits (half rounds toward +infinity).
- R7: A rounded value outside the signed OW-bit range is clipped to 2^(OW-1)-1 or to -2^(OW-1).
- R8: In the good state, the state becomes bad at the next edge when pwr_est < thr_lo (unsigned). When pwr_est equals thr_lo or is higher, the state stays good.
- R9: In the bad state, the state becomes good at the next edge only when pwr_est > thr_hi (unsigned). Any value up to and including thr_hi keeps it bad.
- R10: On each accepted sample, cfg_active takes cfg_bad if the channel state before that edge is bad, and cfg_good otherwise. That vector gates the sample's taps. cfg_active does not change on edges without an accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| coef_flat | input | TAPS*CW | Signed coefficients, tap k in bits [k*CW +: CW] |
| cfg_good | input | TAPS | Tap enable vector for the good state |
| cfg_bad | input | TAPS | Tap enable vector for the bad state |
| pwr_est | input | PW | Unsigned received-power estimate |
| thr_lo | input | PW | Threshold to enter the bad state |
| thr_hi | input | PW | Threshold to return to the good state |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | OW | Rounded, saturated filter output |
| chan_bad | output | 1 | Channel state, 1 = bad |
| cfg_active | output | TAPS | Enable vector in use |

## Verification
A channel transition and a sample acceptance can fall on the same clock edge. In that case the captured vector must be the one for the state before the transition. The following sample must then use the vector for the new state. The bench provokes this by dropping pwr_est under thr_lo in the same cycle that it presents a sample, with disjoint good and bad vectors. The bench then compares cfg_active, chan_bad and both outputs against its own model, which applies the old state to the first sample and the new state to the second.

// File: rtl/tapfir_pkg.sv
package tapfir_pkg;
  typedef enum logic {
    CH_GOOD = 1'b0,
    CH_BAD  = 1'b1
  } chan_e;
endpackage

// File: rtl/tapfir_chan.sv
module tapfir_chan
  import tapfir_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pwr_est,
  input  logic [PW-1:0] thr_lo,
  input  logic [PW-1:0] thr_hi,
  output chan_e         state,
  output logic          go_bad,
  output logic          go_good
);
  // Transition events are exposed so the checker can watch them directly.
  always_comb begin
    go_bad  = (state == CH_GOOD) && (pwr_est < thr_lo);
    go_good = (state == CH_BAD)  && (pwr_est > thr_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= CH_GOOD;
    else if (go_bad)  state <= CH_BAD;
    else if (go_good) state <= CH_GOOD;
  end
endmodule

// File: rtl/tapfir_taps.sv
module tapfir_taps #(
  parameter int TAPS = 4,
  parameter int DW   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_sample,
  input  logic [TAPS-1:0]    tap_sel,
  output logic [TAPS*DW-1:0] ops_flat,
  output logic [TAPS-1:0]    en_q,
  output logic               st1_valid
);
  logic [DW-1:0] tap_in [TAPS];
  logic [DW-1:0] hist   [TAPS-1];
  logic [DW-1:0] op_q   [TAPS];

  assign tap_in[0] = in_sample;

  for (genvar k = 1; k < TAPS; k++) begin : g_link
    assign tap_in[k] = hist[k-1];
  end

  // Delay line shifts on every accepted sample, independent of enables.
  for (genvar k = 0; k < TAPS-1; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n)        hist[k] <= '0;
      else if (in_valid) hist[k] <= tap_in[k];
    end
  end

  // Operand registers load only for enabled taps; disabled ones stay frozen.
  for (genvar k = 0; k < TAPS; k++) begin : g_op
    always_ff @(posedge clk) begin
      if (!rst_n)                      op_q[k] <= '0;
      else if (in_valid && tap_sel[k]) op_q[k] <= tap_in[k];
    end
    assign ops_flat[k*DW +: DW] = op_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      st1_valid <= 1'b0;
    end else begin
      st1_valid <= in_valid;
      if (in_valid) en_q <= tap_sel;
    end
  end
endmodule

// File: rtl/tapfir_sum.sv
module tapfir_sum #(
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int OW   = 12,
  parameter int RS   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st1_valid,
  input  logic [TAPS*DW-1:0] ops_flat,
  input  logic [TAPS*CW-1:0] coef_flat,
  input  logic [TAPS-1:0]    en_q,
  output logic               sat_hit,
  output logic               out_valid,
  output logic [OW-1:0]      out_sample
);
  localparam int PRW = DW + CW;
  localparam int AW  = PRW + $clog2(TAPS) + 1;
  localparam logic signed [AW:0] HALF = {{(AW-RS+1){1'b0}}, 1'b1, {(RS-1){1'b0}}};
  localparam logic signed [AW:0] OMAX = {{(AW-OW+2){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW:0] OMIN = {{(AW-OW+2){1'b1}}, {(OW-1){1'b0}}};

  function automatic logic signed [AW:0] round_shift(input logic signed [AW-1:0] v);
    logic signed [AW:0] ext;
    ext = {v[AW-1], v};
    ext = ext + HALF;
    return ext >>> RS;
  endfunction

  function automatic logic [OW-1:0] clip(input logic signed [AW:0] r);
    logic signed [AW:0] c;
    if (r > OMAX)      c = OMAX;
    else if (r < OMIN) c = OMIN;
    else               c = r;
    return c[OW-1:0];
  endfunction

  logic signed [AW-1:0]  acc;
  logic signed [PRW-1:0] prod;
  logic signed [AW:0]    rnd;

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int k = 0; k < TAPS; k++) begin
      prod = $signed(ops_flat[k*DW +: DW]) * $signed(coef_flat[k*CW +: CW]);
      if (en_q[k]) acc = acc + AW'(prod);
    end
    rnd     = round_shift(acc);
    sat_hit = (rnd > OMAX) || (rnd < OMIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= st1_valid;
      if (st1_valid) out_sample <= clip(rnd);
    end
  end
endmodule

// File: rtl/tapfir_top.sv
module tapfir_top
  import tapfir_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int OW   = 12,
  parameter int RS   = 10,
  parameter int PW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_sample,
  input  logic [TAPS*CW-1:0] coef_flat,
  input  logic [TAPS-1:0]    cfg_good,
  input  logic [TAPS-1:0]    cfg_bad,
  input  logic [PW-1:0]      pwr_est,
  input  logic [PW-1:0]      thr_lo,
  input  logic [PW-1:0]      thr_hi,
  output logic               out_valid,
  output logic [OW-1:0]      out_sample,
  output logic               chan_bad,
  output logic [TAPS-1:0]    cfg_active
);
  chan_e               chan_state;
  logic                go_bad;
  logic                go_good;
  logic [TAPS-1:0]     tap_sel;
  logic [TAPS*DW-1:0]  ops_flat;
  logic                st1_valid;
  logic                sat_hit;

  tapfir_chan #(.PW(PW)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_est (pwr_est),
    .thr_lo  (thr_lo),
    .thr_hi  (thr_hi),
    .state   (chan_state),
    .go_bad  (go_bad),
    .go_good (go_good)
  );

  assign chan_bad = (chan_state == CH_BAD);
  assign tap_sel  = chan_bad ? cfg_bad : cfg_good;

  tapfir_taps #(.TAPS(TAPS), .DW(DW)) u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .tap_sel   (tap_sel),
    .ops_flat  (ops_flat),
    .en_q      (cfg_active),
    .st1_valid (st1_valid)
  );

  tapfir_sum #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .RS(RS)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .st1_valid  (st1_valid),
    .ops_flat   (ops_flat),
    .coef_flat  (coef_flat),
    .en_q       (cfg_active),
    .sat_hit    (sat_hit),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );
endmodule

// File: rtl/tapfir_chk.sv
module tapfir_chk #(
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int OW   = 12,
  parameter int PW   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [PW-1:0]      pwr_est,
  input logic [PW-1:0]      thr_lo,
  input logic [PW-1:0]      thr_hi,
  input logic               chan_bad,
  input logic               go_bad,
  input logic               go_good,
  input logic [TAPS-1:0]    tap_sel,
  input logic [TAPS-1:0]    cfg_active,
  input logic [TAPS*DW-1:0] ops_flat,
  input logic               st1_valid,
  input logic               sat_hit,
  input logic               out_valid,
  input logic [OW-1:0]      out_sample
);
  localparam logic [OW-1:0] PMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] PMIN = {1'b1, {(OW-1){1'b0}}};

  // R8
  good_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_bad && pwr_est >= thr_lo) |=> !chan_bad);

  // R8
  go_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_bad |=> chan_bad);

  // R9
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_bad && pwr_est <= thr_hi) |=> chan_bad);

  // R9
  go_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_good |=> !chan_bad);

  // R10
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cfg_active));

  // R3
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st1_valid |=> out_valid);

  // R3
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st1_valid |=> !out_valid);

  // R7
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st1_valid && sat_hit) |=> (out_sample == PMAX || out_sample == PMIN));

  for (genvar k = 0; k < TAPS; k++) begin : g_hold
    // R4
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && tap_sel[k]) |=> $stable(ops_flat[k*DW +: DW]));
  end
endmodule

bind tapfir_top tapfir_chk #(.TAPS(TAPS), .DW(DW), .OW(OW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .pwr_est    (pwr_est),
  .thr_lo     (thr_lo),
  .thr_hi     (thr_hi),
  .chan_bad   (chan_bad),
  .go_bad     (go_bad),
  .go_good    (go_good),
  .tap_sel    (tap_sel),
  .cfg_active (cfg_active),
  .ops_flat   (ops_flat),
  .st1_valid  (st1_valid),
  .sat_hit    (sat_hit),
  .out_valid  (out_valid),
  .out_sample (out_sample)
);

// File: tb/tapfir_top_bench.sv
module tapfir_top_bench;
  localparam int TAPS = 4;
  localparam int DW   = 12;
  localparam int CW   = 12;
  localparam int OW   = 12;
  localparam int RS   = 10;
  localparam int PW   = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [DW-1:0]      in_sample = '0;
  logic [TAPS*CW-1:0] coef_flat = '0;
  logic [TAPS-1:0]    cfg_good = '1;
  logic [TAPS-1:0]    cfg_bad = '0;
  logic [PW-1:0]      pwr_est = 10'd500;
  logic [PW-1:0]      thr_lo = 10'd200;
  logic [PW-1:0]      thr_hi = 10'd700;
  logic               out_valid;
  logic [OW-1:0]      out_sample;
  logic               chan_bad;
  logic [TAPS-1:0]    cfg_active;

  tapfir_top #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .RS(RS), .PW(PW)) u_tapfir_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_flat(coef_flat), .cfg_good(cfg_good), .cfg_bad(cfg_bad),
    .pwr_est(pwr_est), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .out_valid(out_valid), .out_sample(out_sample),
    .chan_bad(chan_bad), .cfg_active(cfg_active)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req  = "R2";
  string cur_chan = "R8";

  // behavioural model state
  int coefs [TAPS];
  int hist [$];
  bit m_bad = 0;
  bit m_v1 = 0;
  bit m_ov = 0;
  int m_pend = 0;
  int m_out = 0;
  int m_act = 0;
  int samp = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rsat(input int s);
    int q;
    q = (s + (1 << (RS-1))) >>> RS;
    if (q > (1 << (OW-1)) - 1) q = (1 << (OW-1)) - 1;
    if (q < -(1 << (OW-1)))    q = -(1 << (OW-1));
    return q;
  endfunction

  task automatic set_coefs(input int c0, input int c1, input int c2, input int c3);
    coefs[0] = c0; coefs[1] = c1; coefs[2] = c2; coefs[3] = c3;
    for (int k = 0; k < TAPS; k++) coef_flat[k*CW +: CW] = CW'(coefs[k]);
  endtask

  task automatic tick();
    bit nb;
    int sel;
    int s;
    @(posedge clk);
    nb = m_bad;
    if (!m_bad && pwr_est < thr_lo) nb = 1;
    else if (m_bad && pwr_est > thr_hi) nb = 0;
    m_ov = m_v1;
    if (m_v1) m_out = m_pend;
    m_v1 = in_valid;
    if (in_valid) begin
      sel = m_bad ? int'(cfg_bad) : int'(cfg_good);
      hist.push_front(samp);
      if (hist.size() > TAPS) void'(hist.pop_back());
      m_act = sel;
      s = 0;
      for (int k = 0; k < hist.size(); k++)
        if (sel[k]) s += coefs[k] * hist[k];
      m_pend = rsat(s);
    end
    m_bad = nb;
    #2;
    chk(out_valid == m_ov, "R3", int'(out_valid), int'(m_ov));
    chk($signed(out_sample) == m_out, m_ov ? cur_req : "R3", int'($signed(out_sample)), m_out);
    chk(chan_bad == m_bad, cur_chan, int'(chan_bad), int'(m_bad));
    chk(int'(cfg_active) == m_act, "R10", int'(cfg_active), m_act);
  endtask

  task automatic send(input int v);
    samp = v;
    in_sample = DW'(v);
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int rnd_samp();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) & 32'hFFF) - 2048;
  endfunction

  initial begin
    set_coefs(100, -200, 300, 400);
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_sample == '0, "R1", int'(out_sample), 0);
    chk(chan_bad == 1'b0, "R1", int'(chan_bad), 0);
    chk(cfg_active == '0, "R1", int'(cfg_active), 0);
    rst_n = 1'b1;
    idle(2);

    // R2 impulse response
    cur_req = "R2";
    send(1024);
    for (int i = 0; i < 5; i++) send(0);
    idle(2);
    // R2 pseudo-random stream, back to back
    for (int i = 0; i < 40; i++) send(rnd_samp());
    // R3 gaps between samples
    cur_req = "R3";
    for (int i = 0; i < 12; i++) begin
      send(rnd_samp());
      idle(i % 3);
    end
    idle(3);

    // R4 two taps disabled
    cur_req = "R4";
    cfg_good = 4'b0101;
    for (int i = 0; i < 12; i++) send(rnd_samp());
    // R5 re-enable: history must be intact
    cur_req = "R5";
    cfg_good = 4'b1111;
    for (int i = 0; i < 6; i++) send(rnd_samp());
    idle(3);

    // R6 rounding on a single unit tap
    cur_req = "R6";
    set_coefs(1, 0, 0, 0);
    cfg_good = 4'b0001;
    send(512); send(511); send(-512); send(-513); send(1536); send(-1);
    idle(3);

    // R7 saturation both ways
    cur_req = "R7";
    set_coefs(2047, 2047, 2047, 2047);
    cfg_good = 4'b1111;
    for (int i = 0; i < 5; i++) send(2047);
    for (int i = 0; i < 5; i++) send(-2048);
    idle(3);

    // R8 threshold edge and entry to bad
    set_coefs(300, -100, 50, 200);
    cfg_good = 4'b0011;
    cfg_bad  = 4'b1100;
    cur_req  = "R10";
    cur_chan = "R8";
    pwr_est = thr_lo;
    idle(3);
    // R10 same-cycle transition and acceptance
    pwr_est = 10'd150;
    send(700);
    pwr_est = 10'd400;
    send(-900);
    send(333);
    idle(2);

    // R9 hysteresis band and exit from bad
    cur_chan = "R9";
    pwr_est = thr_hi;
    idle(3);
    send(1200);
    pwr_est = 10'd701;
    send(-50);
    pwr_est = 10'd300;
    send(800);
    send(-1500);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule